// File: doc/BRIEF.md
# Power Mode State Controller

This block is the digital control core of a power management device. It keeps the device in one of four operating modes: off, standby, active and charging standby. From the current mode and the charger/USB presence flag, a fixed decode drives enable lines for the regulator groups, the charger, the converter, the serial control interface, the system oscillator and the battery monitor.

A host moves the controller between modes with a one-cycle request. Fault flags from the analog side override the host. A thermal shutdown flag forces standby. A battery-critical flag forces power off and outranks everything else. An earlier thermal warning does not change the mode. It sets a sticky status that drives a maskable interrupt line until software clears it. An active-low system reset output stays asserted in every mode except active. In active it is released only after a programmable number of cycles, and that count starts again each time active is entered.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `por_n` is low, the mode reads off (code 0), every enable output is low, `rst_n_out` is low and `irq` is low.
- R2: Mode codes are off=0, standby=1, active=2, charging standby=3. In off, every enable output is low.
- R3: In standby, only `en_batmon` is high.
- R4: In active, all `en_reg` bits, `en_conv`, `en_serial`, `en_osc` and `en_batmon` are high. `en_chg` follows `chg_present`.
- R5: In charging standby, `en_serial`, `en_osc` and `en_batmon` are high, `en_reg` and `en_conv` are low, and `en_chg` follows `chg_present`.
- R6: A `host_req_valid` pulse with `therm_shdn` and `batt_crit` both low loads `host_req_mode` into the mode at the next clock edge.
- R7: With `therm_shdn` high and `batt_crit` low, the mode is standby after the next edge, whatever the host requests.
- R8: With `batt_crit` high, the mode is off after the next edge. This overrides `therm_shdn` and any host request.
- R9: `rst_n_out` is low outside active. It goes high `RST_DELAY` edges after the edge that entered active.
- R10: Leaving active drops `rst_n_out` at once. Each new entry into active waits the full `RST_DELAY` again.
- R11: `therm_alarm` sampled high at an edge sets the interrupt status without changing the mode. `irq` equals the status while `irq_mask` is low and is low while `irq_mask` is high.
- R12: The status holds until an edge that samples `irq_clear` high with `therm_alarm` low. If both are high at the same edge, the status stays set. Masking never clears the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| chg_present | input | 1 | Charger or USB supply present |
| host_req_valid | input | 1 | One-cycle host mode request strobe |
| host_req_mode | input | 2 | Requested mode code |
| therm_alarm | input | 1 | Over-temperature warning flag |
| therm_shdn | input | 1 | Over-temperature shutdown flag |
| batt_crit | input | 1 | Battery-critical flag |
| irq_mask | input | 1 | Interrupt mask, high hides the request |
| irq_clear | input | 1 | Clears the latched interrupt status |
| mode | output | 2 | Current mode code |
| en_reg | output | REG_GROUPS | Regulator group enables |
| en_chg | output | 1 | Charger enable |
| en_conv | output | 1 | Converter enable |
| en_serial | output | 1 | Serial interface enable |
| en_osc | output | 1 | System oscillator enable |
| en_batmon | output | 1 | Battery monitor enable |
| irq | output | 1 | Level interrupt request |
| rst_n_out | output | 1 | Active-low system reset |

## Verification
The bench builds the block with `REG_GROUPS=3`, `CNT_W=3`, `RST_DELAY=3` and the unregistered reset output. These values keep the reset-release window short, so the bench can walk through all three count steps and see the release on the exact edge. It also re-enters active and watches the count start again, all within a few dozen cycles. Three regulator groups show that the regulator enable is copied to every group. The registered reset-output variant is covered only by the checker's rule that the reset stays low for two cycles outside active.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [1:0] {
      PM_OFF  = 2'd0,
      PM_STBY = 2'd1,
      PM_ACT  = 2'd2,
      PM_CHG  = 2'd3
   } pm_mode_e;

   typedef struct packed {
      logic regs;
      logic chg;
      logic conv;
      logic serial;
      logic osc;
      logic batmon;
   } pm_en_s;

   localparam pm_en_s PM_EN_NONE = '{default: 1'b0};

endpackage

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
   import pwr_mode_pkg::*;
#(
   parameter pm_mode_e RESET_MODE = PM_OFF
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       host_valid,
   input  logic [1:0] host_mode,
   input  logic       shdn,
   input  logic       crit,
   output pm_mode_e   mode_q
);

   pm_mode_e mode_d;

   always_comb begin
      mode_d = mode_q;
      if (crit) begin
         mode_d = PM_OFF;
      end else if (shdn) begin
         mode_d = PM_STBY;
      end else if (host_valid) begin
         mode_d = pm_mode_e'(host_mode);
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mode_q <= RESET_MODE;
      end else begin
         mode_q <= mode_d;
      end
   end

endmodule

// File: rtl/pm_en_decode.sv
module pm_en_decode
   import pwr_mode_pkg::*;
(
   input  pm_mode_e mode,
   input  logic     chg_present,
   output pm_en_s   en
);

   always_comb begin
      en = PM_EN_NONE;
      unique case (mode)
         PM_OFF: begin
            en = PM_EN_NONE;
         end
         PM_STBY: begin
            en.batmon = 1'b1;
         end
         PM_ACT: begin
            en.regs   = 1'b1;
            en.conv   = 1'b1;
            en.serial = 1'b1;
            en.osc    = 1'b1;
            en.batmon = 1'b1;
            en.chg    = chg_present;
         end
         PM_CHG: begin
            en.serial = 1'b1;
            en.osc    = 1'b1;
            en.batmon = 1'b1;
            en.chg    = chg_present;
         end
         default: en = PM_EN_NONE;
      endcase
   end

endmodule

// File: rtl/pm_rst_timer.sv
module pm_rst_timer #(
   parameter int CNT_W       = 8,
   parameter int RST_DELAY   = 200,
   parameter bit RST_OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic por_n,
   input  logic in_active,
   output logic rst_n_out
);

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RST_DELAY);

   logic [CNT_W-1:0] cnt_q;
   logic             release_c;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
      end else if (!in_active) begin
         cnt_q <= '0;
      end else if (cnt_q != LIMIT) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign release_c = in_active && (cnt_q == LIMIT);

   generate
      if (RST_OUT_REG) begin : g_reg_out
         logic rel_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               rel_q <= 1'b0;
            end else begin
               rel_q <= release_c;
            end
         end
         assign rst_n_out = rel_q;
      end else begin : g_comb_out
         assign rst_n_out = release_c;
      end
   endgenerate

endmodule

// File: rtl/pm_irq_latch.sv
module pm_irq_latch (
   input  logic clk,
   input  logic por_n,
   input  logic set,
   input  logic clear,
   input  logic mask,
   output logic irq
);

   logic sts_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sts_q <= 1'b0;
      end else if (set) begin
         sts_q <= 1'b1;
      end else if (clear) begin
         sts_q <= 1'b0;
      end
   end

   assign irq = sts_q & ~mask;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int REG_GROUPS  = 3,
   parameter int CNT_W       = 8,
   parameter int RST_DELAY   = 200,
   parameter bit RST_OUT_REG = 1'b0
) (
   input  logic                  clk,
   input  logic                  por_n,
   input  logic                  chg_present,
   input  logic                  host_req_valid,
   input  logic [1:0]            host_req_mode,
   input  logic                  therm_alarm,
   input  logic                  therm_shdn,
   input  logic                  batt_crit,
   input  logic                  irq_mask,
   input  logic                  irq_clear,
   output logic [1:0]            mode,
   output logic [REG_GROUPS-1:0] en_reg,
   output logic                  en_chg,
   output logic                  en_conv,
   output logic                  en_serial,
   output logic                  en_osc,
   output logic                  en_batmon,
   output logic                  irq,
   output logic                  rst_n_out
);

   generate
      if (REG_GROUPS < 1) begin : g_bad_groups
         $error("REG_GROUPS must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 31) begin : g_bad_width
         $error("CNT_W must lie in 1..31");
      end
      if (RST_DELAY < 0 || RST_DELAY >= (1 << CNT_W)) begin : g_bad_delay
         $error("RST_DELAY must fit in CNT_W bits");
      end
   endgenerate

   pm_mode_e mode_q;
   pm_en_s   en;

   pm_mode_fsm #(.RESET_MODE(PM_OFF)) u_fsm (
      .clk        (clk),
      .por_n      (por_n),
      .host_valid (host_req_valid),
      .host_mode  (host_req_mode),
      .shdn       (therm_shdn),
      .crit       (batt_crit),
      .mode_q     (mode_q)
   );

   pm_en_decode u_dec (
      .mode        (mode_q),
      .chg_present (chg_present),
      .en          (en)
   );

   pm_rst_timer #(
      .CNT_W       (CNT_W),
      .RST_DELAY   (RST_DELAY),
      .RST_OUT_REG (RST_OUT_REG)
   ) u_rst (
      .clk       (clk),
      .por_n     (por_n),
      .in_active (mode_q == PM_ACT),
      .rst_n_out (rst_n_out)
   );

   pm_irq_latch u_irq (
      .clk   (clk),
      .por_n (por_n),
      .set   (therm_alarm),
      .clear (irq_clear),
      .mask  (irq_mask),
      .irq   (irq)
   );

   genvar g;
   generate
      for (g = 0; g < REG_GROUPS; g++) begin : g_reg_en
         assign en_reg[g] = en.regs;
      end
   endgenerate

   assign mode      = mode_q;
   assign en_chg    = en.chg;
   assign en_conv   = en.conv;
   assign en_serial = en.serial;
   assign en_osc    = en.osc;
   assign en_batmon = en.batmon;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
   parameter int REG_GROUPS = 3
) (
   input logic                  clk,
   input logic                  por_n,
   input logic                  chg_present,
   input logic                  host_req_valid,
   input logic [1:0]            host_req_mode,
   input logic                  therm_shdn,
   input logic                  batt_crit,
   input logic                  irq_mask,
   input logic                  irq_clear,
   input logic [1:0]            mode,
   input logic [REG_GROUPS-1:0] en_reg,
   input logic                  en_chg,
   input logic                  en_conv,
   input logic                  en_serial,
   input logic                  en_osc,
   input logic                  en_batmon,
   input logic                  irq,
   input logic                  rst_n_out
);

   a_r2_off_quiet: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 2'd0) |-> (en_reg == '0 && !en_chg && !en_conv && !en_serial && !en_osc && !en_batmon));

   a_r3_stby_monitor_only: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 2'd1) |-> (en_reg == '0 && !en_chg && !en_conv && !en_serial && !en_osc && en_batmon));

   a_r4_active_on: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 2'd2) |-> (en_reg == '1 && en_conv && en_serial && en_osc && en_batmon && en_chg == chg_present));

   a_r5_chg_stby: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 2'd3) |-> (en_reg == '0 && !en_conv && en_serial && en_osc && en_batmon && en_chg == chg_present));

   a_r6_host_load: assert property (@(posedge clk) disable iff (!por_n)
      (host_req_valid && !therm_shdn && !batt_crit) |=> (mode == $past(host_req_mode)));

   a_r7_shdn_standby: assert property (@(posedge clk) disable iff (!por_n)
      (therm_shdn && !batt_crit) |=> (mode == 2'd1));

   a_r8_crit_off: assert property (@(posedge clk) disable iff (!por_n)
      batt_crit |=> (mode == 2'd0));

   a_r9_rst_low_outside: assert property (@(posedge clk) disable iff (!por_n)
      (mode != 2'd2 && $past(mode) != 2'd2) |-> !rst_n_out);

   a_r11_mask_hides: assert property (@(posedge clk) disable iff (!por_n)
      irq_mask |-> !irq);

   a_r12_status_holds: assert property (@(posedge clk) disable iff (!por_n)
      (irq && !irq_clear) |=> (irq || irq_mask));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.REG_GROUPS(REG_GROUPS)) u_chk (
   .clk            (clk),
   .por_n          (por_n),
   .chg_present    (chg_present),
   .host_req_valid (host_req_valid),
   .host_req_mode  (host_req_mode),
   .therm_shdn     (therm_shdn),
   .batt_crit      (batt_crit),
   .irq_mask       (irq_mask),
   .irq_clear      (irq_clear),
   .mode           (mode),
   .en_reg         (en_reg),
   .en_chg         (en_chg),
   .en_conv        (en_conv),
   .en_serial      (en_serial),
   .en_osc         (en_osc),
   .en_batmon      (en_batmon),
   .irq            (irq),
   .rst_n_out      (rst_n_out)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;

   localparam int RG = 3;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          chg_present = 1'b0;
   logic          host_req_valid = 1'b0;
   logic [1:0]    host_req_mode = 2'd0;
   logic          therm_alarm = 1'b0;
   logic          therm_shdn = 1'b0;
   logic          batt_crit = 1'b0;
   logic          irq_mask = 1'b0;
   logic          irq_clear = 1'b0;
   logic [1:0]    mode;
   logic [RG-1:0] en_reg;
   logic          en_chg, en_conv, en_serial, en_osc, en_batmon, irq, rst_n_out;

   pwr_mode_ctrl #(.REG_GROUPS(RG), .CNT_W(3), .RST_DELAY(3), .RST_OUT_REG(1'b0)) dut (
      .clk(clk), .por_n(por_n), .chg_present(chg_present),
      .host_req_valid(host_req_valid), .host_req_mode(host_req_mode),
      .therm_alarm(therm_alarm), .therm_shdn(therm_shdn), .batt_crit(batt_crit),
      .irq_mask(irq_mask), .irq_clear(irq_clear), .mode(mode), .en_reg(en_reg),
      .en_chg(en_chg), .en_conv(en_conv), .en_serial(en_serial), .en_osc(en_osc),
      .en_batmon(en_batmon), .irq(irq), .rst_n_out(rst_n_out)
   );

   always #5 clk = ~clk;

   typedef struct {
      logic [1:0] mode;
      logic       chgp;
      logic       rst;
      logic       irq;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;

   // staged stimulus, applied by the driver at a falling edge
   logic       s_hv = 1'b0, s_shdn = 1'b0, s_crit = 1'b0, s_alarm = 1'b0;
   logic       s_mask = 1'b0, s_clr = 1'b0, s_chg = 1'b0;
   logic [1:0] s_m = 2'd0;

   // enables expected from the mode table: {en_reg, chg, conv, serial, osc, batmon}
   function automatic logic [RG+4:0] exp_en(input logic [1:0] m, input logic c);
      case (m)
         2'd1:    return {{RG{1'b0}}, 5'b00001};
         2'd2:    return {{RG{1'b1}}, c, 4'b1111};
         2'd3:    return {{RG{1'b0}}, c, 4'b0111};
         default: return '0;
      endcase
   endfunction

   task automatic compare(input exp_t e);
      logic [RG+4:0] got_en, want_en;
      got_en  = {en_reg, en_chg, en_conv, en_serial, en_osc, en_batmon};
      want_en = exp_en(e.mode, e.chgp);
      total++;
      if (mode !== e.mode || got_en !== want_en || rst_n_out !== e.rst || irq !== e.irq) begin
         bad++;
         $display("FAIL %s: mode=%0d en=%b rst=%b irq=%b expected mode=%0d en=%b rst=%b irq=%b",
                  e.tag, mode, got_en, rst_n_out, irq, e.mode, want_en, e.rst, e.irq);
      end
   endtask

   // monitor: checks one expected item after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) compare(q.pop_front());
      end
   end

   // driver: apply staged inputs, push the outcome due after the next edge
   task automatic step(input logic [1:0] em, input logic er, input logic ei, input string tag);
      exp_t e;
      @(negedge clk);
      host_req_valid = s_hv;  host_req_mode = s_m;
      therm_shdn = s_shdn;    batt_crit = s_crit;
      therm_alarm = s_alarm;  irq_mask = s_mask;
      irq_clear = s_clr;      chg_present = s_chg;
      e.mode = em; e.chgp = s_chg; e.rst = er; e.irq = ei; e.tag = tag;
      q.push_back(e);
      s_hv = 1'b0; s_clr = 1'b0;
   endtask

   task automatic req(input logic [1:0] m);
      s_hv = 1'b1; s_m = m;
   endtask

   initial begin
      exp_t r;
      r.mode = 2'd0; r.chgp = 1'b0; r.rst = 1'b0; r.irq = 1'b0; r.tag = "R1 reset";
      repeat (3) @(negedge clk);
      compare(r);
      chg_present = 1'b1; therm_alarm = 1'b1;
      #1 r.chgp = 1'b1; r.tag = "R1 reset ignores inputs";
      @(negedge clk);
      compare(r);
      chg_present = 1'b0; therm_alarm = 1'b0;
      por_n = 1'b1;

      req(2'd1);                 step(2'd1, 1'b0, 1'b0, "R6 R3 host to standby");
      step(2'd1, 1'b0, 1'b0, "R2 R3 hold standby");
      req(2'd2);                 step(2'd2, 1'b0, 1'b0, "R6 R4 enter active");
      step(2'd2, 1'b0, 1'b0, "R9 count 1");
      step(2'd2, 1'b0, 1'b0, "R9 count 2");
      step(2'd2, 1'b1, 1'b0, "R9 released after delay");
      s_chg = 1'b1;              step(2'd2, 1'b1, 1'b0, "R4 charger follows supply");
      s_alarm = 1'b1; s_mask = 1'b1;
                                 step(2'd2, 1'b1, 1'b0, "R11 masked alarm, mode kept");
      s_alarm = 1'b0; s_mask = 1'b0;
                                 step(2'd2, 1'b1, 1'b1, "R12 unmask shows held status");
      step(2'd2, 1'b1, 1'b1, "R12 status holds");
      s_clr = 1'b1;              step(2'd2, 1'b1, 1'b0, "R12 clear drops irq");
      req(2'd3);                 step(2'd3, 1'b0, 1'b0, "R10 R5 leave active");
      req(2'd2);                 step(2'd2, 1'b0, 1'b0, "R10 re-enter restarts");
      step(2'd2, 1'b0, 1'b0, "R10 count 1");
      step(2'd2, 1'b0, 1'b0, "R10 count 2");
      step(2'd2, 1'b1, 1'b0, "R10 released again");
      s_shdn = 1'b1; req(2'd2);  step(2'd1, 1'b0, 1'b0, "R7 shutdown forces standby");
      req(2'd2);                 step(2'd1, 1'b0, 1'b0, "R7 host ignored in shutdown");
      s_shdn = 1'b0; s_crit = 1'b1; req(2'd2);
                                 step(2'd0, 1'b0, 1'b0, "R8 critical forces off");
      s_shdn = 1'b1;             step(2'd0, 1'b0, 1'b0, "R8 critical beats shutdown");
      s_shdn = 1'b0; s_crit = 1'b0; s_chg = 1'b0; req(2'd3);
                                 step(2'd3, 1'b0, 1'b0, "R5 charging standby no supply");
      s_chg = 1'b1;              step(2'd3, 1'b0, 1'b0, "R5 charging standby with supply");
      s_alarm = 1'b1; s_clr = 1'b1;
                                 step(2'd3, 1'b0, 1'b1, "R12 set wins over clear");
      s_alarm = 1'b0; s_clr = 1'b1;
                                 step(2'd3, 1'b0, 1'b0, "R12 clear after alarm");
      req(2'd0);                 step(2'd0, 1'b0, 1'b0, "R6 R2 host to off");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule